// File: doc/BRIEF.md
# Multiplexed LCD Common and Segment Scanner

This block turns the contents of a small display memory into multiplexed drive waveforms for a passive LCD panel with up to four common lines and thirty-two segment lines. The memory holds one 4-bit word per segment: the word at address s belongs to segment s, and bit c of that word lights the pixel where segment s crosses common c. Every output line carries a 2-bit level code (0 to 3 standing for the drive levels V0 to V3) rather than an analog voltage. An external bias network turns those codes into panel voltages.

The scan advances one step per driving period. By default a step is 128 system clocks, which gives a 256 Hz step rate from a 32.768 kHz system clock. At the start of every step the block sweeps the display memory through its read port, one address per clock. It gathers the bit of the currently selected common from each word and then refreshes all outputs at once. The common index walks through the active commons. The waveform polarity flips on every step, so the panel sees no net DC. Configuration inputs choose two, three or four commons and 1/2 or 1/3 bias. A display-on input and a system-enable input blank the panel.

Top module: `lcd_scan`

## Requirements
- R1: Segment output s shows the bit of memory word s that belongs to the common selected in the current step, and common c corresponds to data bit c.
- R2: The selected common drives code 3 in a positive step and code 0 in a negative step. A lit segment drives the opposite extreme: code 0 in a positive step and code 3 in a negative step.
- R3: With 1/3 bias (biasThird=1), an unselected common drives code 1 in a positive step and code 2 in a negative step. An unlit segment drives code 2 in a positive step and code 1 in a negative step.
- R4: With 1/2 bias (biasThird=0), unselected commons and unlit segments drive code 1, and code 2 never appears on any output.
- R5: Polarity alternates on every step. The first step after the display is enabled is positive and selects common 0.
- R6: comSel picks the number of active commons: 2'b00 gives 2, 2'b01 gives 3, 2'b10 gives 4, and 2'b11 is treated as 4. The selected common runs 0, 1, ... n-1 and then wraps to 0.
- R7: Each step lasts TICK_DIV clocks. The next memory sweep starts exactly TICK_DIV clocks after the previous one.
- R8: When lcdOn or sysEn is low, every common and segment output is code 0 one clock later and no memory reads are issued. Re-enabling restarts the scan as in R5.
- R9: At the start of each step, ramRdEn is high for NUM_SEG consecutive clocks with ramAddr running 0 to NUM_SEG-1. ramData is taken one clock after each address. The outputs refresh NUM_SEG+2 clocks after the step starts.
- R10: If the display is disabled on the same clock that the outputs would refresh, the outputs stay at code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sysEn | input | 1 | System enable; low blanks all outputs |
| lcdOn | input | 1 | Display on; low blanks all outputs |
| comSel | input | 2 | Number of active commons (00:2, 01:3, 10/11:4) |
| biasThird | input | 1 | 1 selects 1/3 bias, 0 selects 1/2 bias |
| ramRdEn | output | 1 | Display memory read strobe |
| ramAddr | output | 6 | Display memory read address (segment number) |
| ramData | input | 4 | Word returned one clock after the read address |
| comLvl | output | 8 | Level codes of the commons, 2 bits each, common 0 in bits 1:0 |
| segLvl | output | 64 | Level codes of the segments, 2 bits each, segment 0 in bits 1:0 |

## Verification
The blanking path and the output refresh can hit the same clock edge. Blanking clears the outputs and resets the scan, while the refresh would load freshly gathered levels. The bench enables the display and counts clocks up to the refresh edge. It then drops lcdOn on the half cycle just before that edge, so both actions meet at one edge, and checks that all outputs read code 0 afterwards. A second step then confirms that re-enabling restarts at common 0 with positive polarity.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  localparam int NUM_COM = 4;
  localparam int NUM_SEG = 32;
  localparam int COM_W   = $clog2(NUM_COM);
  localparam int SEG_W   = $clog2(NUM_SEG);
  localparam int LVL_W   = 2;

  typedef logic [LVL_W-1:0] lvl_t;

  typedef struct packed {
    logic             clear;
    logic             capture;
    logic [SEG_W-1:0] capIdx;
    logic             load;
    logic [COM_W-1:0] comIdx;
    logic             pol;
  } scan_strb_t;

  // number of active commons for a configuration code
  function automatic logic [COM_W:0] activeComs(input logic [1:0] sel);
    case (sel)
      2'b00:   activeComs = (COM_W+1)'(2);
      2'b01:   activeComs = (COM_W+1)'(3);
      default: activeComs = (COM_W+1)'(4);
    endcase
  endfunction

  function automatic lvl_t selLvl(input logic neg);
    selLvl = neg ? lvl_t'(0) : lvl_t'(3);
  endfunction

  function automatic lvl_t unselLvl(input logic neg, input logic third);
    if (!third) unselLvl = lvl_t'(1);
    else        unselLvl = neg ? lvl_t'(2) : lvl_t'(1);
  endfunction

  function automatic lvl_t onLvl(input logic neg);
    onLvl = neg ? lvl_t'(3) : lvl_t'(0);
  endfunction

  function automatic lvl_t offLvl(input logic neg, input logic third);
    if (!third) offLvl = lvl_t'(1);
    else        offLvl = neg ? lvl_t'(1) : lvl_t'(2);
  endfunction
endpackage

// File: rtl/lcd_scan_ctrl.sv
module lcd_scan_ctrl
  import lcd_scan_pkg::*;
#(
  parameter int TICK_DIV = 128,
  parameter int ADDR_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sysEn,
  input  logic              lcdOn,
  input  logic [1:0]        comSel,
  output logic              ramRdEn,
  output logic [ADDR_W-1:0] ramAddr,
  output scan_strb_t        strb
);
  localparam int DIV_W = $clog2(TICK_DIV);
  localparam logic [DIV_W-1:0] LAST_CNT = DIV_W'(TICK_DIV - 1);
  localparam logic [DIV_W-1:0] SEG_CNT  = DIV_W'(NUM_SEG);
  localparam logic [DIV_W-1:0] LOAD_CNT = DIV_W'(NUM_SEG + 1);

  logic             scanEn;
  logic [DIV_W-1:0] divCnt;
  logic [COM_W-1:0] comIdx;
  logic             pol;
  logic [COM_W:0]   nAct;
  logic             atWrap;
  logic             lastCom;

  assign scanEn  = sysEn && lcdOn;
  assign nAct    = activeComs(comSel);
  assign atWrap  = (divCnt == LAST_CNT);
  assign lastCom = (({1'b0, comIdx} + (COM_W+1)'(1)) >= nAct);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divCnt <= '0;
      comIdx <= '0;
      pol    <= 1'b0;
    end else if (!scanEn) begin
      divCnt <= '0;
      comIdx <= '0;
      pol    <= 1'b0;
    end else if (atWrap) begin
      divCnt <= '0;
      comIdx <= lastCom ? '0 : comIdx + COM_W'(1);
      pol    <= ~pol;
    end else begin
      divCnt <= divCnt + DIV_W'(1);
    end
  end

  assign ramRdEn = scanEn && (divCnt < SEG_CNT);
  assign ramAddr = ADDR_W'(divCnt);

  always_comb begin
    strb         = '0;
    strb.clear   = !scanEn;
    strb.capture = scanEn && (divCnt != '0) && (divCnt <= SEG_CNT);
    strb.capIdx  = SEG_W'(divCnt - DIV_W'(1));
    strb.load    = scanEn && (divCnt == LOAD_CNT);
    strb.comIdx  = comIdx;
    strb.pol     = pol;
  end

  // R9: reads stay inside the segment range
  a_r9_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
    ramRdEn |-> (ramAddr < ADDR_W'(NUM_SEG)));

  // R5: polarity flips at each step boundary
  a_r5_pol_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (scanEn && atWrap) |=> (pol != $past(pol)));

  // R6: common index wraps after the last active common
  a_r6_com_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (scanEn && atWrap && lastCom) |=> (comIdx == '0));

  // R8: a blanked scan issues no reads
  a_r8_no_read_off: assert property (@(posedge clk) disable iff (!rst_n)
    !scanEn |-> !ramRdEn);
endmodule

// File: rtl/lcd_scan_dp.sv
module lcd_scan_dp
  import lcd_scan_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  scan_strb_t               strb,
  input  logic                     biasThird,
  input  logic [NUM_COM-1:0]       ramData,
  output logic [NUM_COM*LVL_W-1:0] comLvl,
  output logic [NUM_SEG*LVL_W-1:0] segLvl
);
  logic [NUM_SEG-1:0]       shadow;
  logic [NUM_COM*LVL_W-1:0] comNext;
  logic [NUM_SEG*LVL_W-1:0] segNext;
  logic                     shown;
  logic [NUM_COM-1:0]       comExtreme;
  logic [NUM_SEG-1:0]       segMid2;
  logic [NUM_COM-1:0]       comMid2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            shadow <= '0;
    else if (strb.capture) shadow[strb.capIdx] <= ramData[strb.comIdx];
  end

  for (genvar c = 0; c < NUM_COM; c++) begin : g_com
    assign comNext[c*LVL_W +: LVL_W] = (strb.comIdx == COM_W'(c))
                                       ? selLvl(strb.pol)
                                       : unselLvl(strb.pol, biasThird);
    assign comExtreme[c] = (comLvl[c*LVL_W +: LVL_W] == 2'd0)
                        || (comLvl[c*LVL_W +: LVL_W] == 2'd3);
    assign comMid2[c]    = (comLvl[c*LVL_W +: LVL_W] == 2'd2);
  end

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    assign segNext[s*LVL_W +: LVL_W] = shadow[s] ? onLvl(strb.pol)
                                                 : offLvl(strb.pol, biasThird);
    assign segMid2[s] = (segLvl[s*LVL_W +: LVL_W] == 2'd2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      comLvl <= '0;
      segLvl <= '0;
      shown  <= 1'b0;
    end else if (strb.clear) begin
      comLvl <= '0;
      segLvl <= '0;
      shown  <= 1'b0;
    end else if (strb.load) begin
      comLvl <= comNext;
      segLvl <= segNext;
      shown  <= 1'b1;
    end
  end

  // R8: blanking zeroes every output one clock later
  a_r8_blank_zero: assert property (@(posedge clk) disable iff (!rst_n)
    strb.clear |=> (comLvl == '0) && (segLvl == '0));

  // R2: exactly one common sits at an extreme level while shown
  a_r2_one_selected: assert property (@(posedge clk) disable iff (!rst_n)
    shown |-> $onehot(comExtreme));

  // R4: a half-bias refresh never produces code 2
  a_r4_no_code2: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.load && !biasThird) |=> ((segMid2 == '0) && (comMid2 == '0)));
endmodule

// File: rtl/lcd_scan.sv
module lcd_scan
  import lcd_scan_pkg::*;
#(
  parameter int TICK_DIV = 128,
  parameter int ADDR_W   = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sysEn,
  input  logic                     lcdOn,
  input  logic [1:0]               comSel,
  input  logic                     biasThird,
  output logic                     ramRdEn,
  output logic [ADDR_W-1:0]        ramAddr,
  input  logic [NUM_COM-1:0]       ramData,
  output logic [NUM_COM*LVL_W-1:0] comLvl,
  output logic [NUM_SEG*LVL_W-1:0] segLvl
);
  scan_strb_t strb;

  lcd_scan_ctrl #(.TICK_DIV(TICK_DIV), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sysEn(sysEn), .lcdOn(lcdOn),
    .comSel(comSel), .ramRdEn(ramRdEn), .ramAddr(ramAddr), .strb(strb)
  );

  lcd_scan_dp u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .biasThird(biasThird),
    .ramData(ramData), .comLvl(comLvl), .segLvl(segLvl)
  );
endmodule

// File: tb/lcd_scan_tb.sv
module lcd_scan_tb;
  localparam int D    = 128;
  localparam int NSEG = 32;
  localparam int NCOM = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sysEn = 1'b0;
  logic        lcdOn = 1'b0;
  logic [1:0]  comSel = 2'b10;
  logic        biasThird = 1'b1;
  logic        ramRdEn;
  logic [5:0]  ramAddr;
  logic [3:0]  ramData;
  logic [7:0]  comLvl;
  logic [63:0] segLvl;
  logic [3:0]  mem [NSEG];
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  always_ff @(posedge clk) if (ramRdEn) ramData <= mem[ramAddr[4:0]];

  lcd_scan u_dut (
    .clk(clk), .rst_n(rst_n), .sysEn(sysEn), .lcdOn(lcdOn), .comSel(comSel),
    .biasThird(biasThird), .ramRdEn(ramRdEn), .ramAddr(ramAddr),
    .ramData(ramData), .comLvl(comLvl), .segLvl(segLvl)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int nComs(input logic [1:0] s);
    return (s == 2'b00) ? 2 : (s == 2'b01) ? 3 : 4;
  endfunction

  function automatic logic [7:0] expCom(input int c, input bit neg, input bit third);
    logic [7:0] v;
    for (int i = 0; i < NCOM; i++)
      v[i*2 +: 2] = (i == c) ? (neg ? 2'd0 : 2'd3)
                  : (!third ? 2'd1 : (neg ? 2'd2 : 2'd1));
    return v;
  endfunction

  function automatic logic [63:0] expSeg(input int c, input bit neg, input bit third);
    logic [63:0] v;
    for (int s = 0; s < NSEG; s++)
      v[s*2 +: 2] = mem[s][c] ? (neg ? 2'd3 : 2'd0)
                  : (!third ? 2'd1 : (neg ? 2'd1 : 2'd2));
    return v;
  endfunction

  task automatic fillMem(input int seed);
    for (int s = 0; s < NSEG; s++) mem[s] = 4'((s * 7 + seed) ^ (s >> 1));
  endtask

  // enable at a negedge; sample each step 64 clocks after it starts
  task automatic runSteps(input string req, input int steps);
    int n;
    n = nComs(comSel);
    @(negedge clk);
    sysEn = 1'b1; lcdOn = 1'b1;
    repeat (64) @(posedge clk);
    @(negedge clk);
    for (int k = 0; k < steps; k++) begin
      check({req, " com"}, {56'd0, comLvl}, {56'd0, expCom(k % n, k[0], biasThird)});
      check({req, " seg"}, segLvl, expSeg(k % n, k[0], biasThird));
      repeat (D) @(posedge clk);
      @(negedge clk);
    end
    lcdOn = 1'b0;
    @(negedge clk);
  endtask

  task automatic tReset();
    check("R8 reset com", {56'd0, comLvl}, 64'd0);
    check("R8 reset seg", segLvl, 64'd0);
    check("R8 reset rd", {63'd0, ramRdEn}, 64'd0);
  endtask

  task automatic tFourThird();   // R1 R2 R3 R5 R6
    fillMem(3); comSel = 2'b10; biasThird = 1'b1;
    runSteps("R1_R3_R5 4com third", 8);
  endtask

  task automatic tThreeHalf();   // R4 R6
    fillMem(11); comSel = 2'b01; biasThird = 1'b0;
    runSteps("R4_R6 3com half", 6);
  endtask

  task automatic tTwo();         // R6
    fillMem(5); comSel = 2'b00; biasThird = 1'b1;
    runSteps("R6 2com", 4);
  endtask

  task automatic tAb11();        // R6 code 11 acts as 4
    fillMem(20); comSel = 2'b11; biasThird = 1'b0;
    runSteps("R6 ab11", 5);
  endtask

  task automatic tReadSweep();   // R9 R7
    int reads;
    reads = 0;
    comSel = 2'b10; biasThird = 1'b1;
    @(negedge clk);
    sysEn = 1'b1; lcdOn = 1'b1;
    #1;
    for (int i = 0; i < D; i++) begin
      if (ramRdEn) begin
        if (ramAddr != 6'(reads)) check("R9 addr order", {58'd0, ramAddr}, 64'(reads));
        reads++;
      end
      @(negedge clk);
    end
    check("R9 read count", 64'(reads), 64'(NSEG));
    check("R7 next sweep rd", {63'd0, ramRdEn}, 64'd1);
    check("R7 next sweep addr", {58'd0, ramAddr}, 64'd0);
    lcdOn = 1'b0;
    @(negedge clk);
  endtask

  task automatic tBlank();       // R8
    fillMem(9); comSel = 2'b10; biasThird = 1'b1;
    @(negedge clk);
    sysEn = 1'b1; lcdOn = 1'b1;
    repeat (D + 64) @(posedge clk);
    @(negedge clk);
    check("R8 running", segLvl, expSeg(1, 1'b1, 1'b1));
    sysEn = 1'b0;
    @(negedge clk);
    check("R8 sysEn low com", {56'd0, comLvl}, 64'd0);
    check("R8 sysEn low seg", segLvl, 64'd0);
    repeat (40) @(negedge clk);
    check("R8 sysEn low rd", {63'd0, ramRdEn}, 64'd0);
    sysEn = 1'b1; lcdOn = 1'b0;
    repeat (80) @(negedge clk);
    check("R8 lcdOn low seg", segLvl, 64'd0);
    check("R8 lcdOn low rd", {63'd0, ramRdEn}, 64'd0);
  endtask

  task automatic tCollide();     // R10 R5
    fillMem(1); comSel = 2'b10; biasThird = 1'b1;
    @(negedge clk);
    sysEn = 1'b1; lcdOn = 1'b1;
    repeat (NSEG + 1) @(posedge clk);
    @(negedge clk);
    lcdOn = 1'b0;                 // next edge is the refresh edge
    @(negedge clk);
    check("R10 collide com", {56'd0, comLvl}, 64'd0);
    check("R10 collide seg", segLvl, 64'd0);
    repeat (5) @(negedge clk);
    lcdOn = 1'b1;
    repeat (64) @(posedge clk);
    @(negedge clk);
    check("R5 restart com", {56'd0, comLvl}, {56'd0, expCom(0, 1'b0, 1'b1)});
    check("R5 restart seg", segLvl, expSeg(0, 1'b0, 1'b1));
    lcdOn = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    fillMem(0);
    repeat (3) @(negedge clk);
    tReset();
    rst_n = 1'b1;
    @(negedge clk);
    tReset();
    tFourThird();
    tThreeHalf();
    tTwo();
    tAb11();
    tReadSweep();
    tBlank();
    tCollide();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule